// File: doc/BRIEF.md
# Pipelined Delayed-LMS Adaptive FIR Filter

This block is a fixed-point adaptive FIR filter for noise cancellation. Each accepted sample brings a reference input `x(n)` and a desired sample `d(n)`. The block produces the filter output `y(n)` and the error `e(n) = d(n) - y(n)`. It adjusts its own coefficients with a least-mean-square rule so that `y` tracks the part of `d` that is correlated with `x`. The error that `e_o` reports is the cleaned signal.

The coefficient loop uses an adaptation delay. Each weight update uses the error and the input vector from `D` samples earlier, where `D = 3 + log2(N_TAPS)` is the latency of the product path. This lets the inner product be fully registered.

Each tap multiplier forms one partial product for every 2-bit group of the sample, using a small multiple-select cell. A registered binary adder tree then sums the taps. The step size is `2^-STEP_SHIFT` and is applied as an arithmetic shift.

Top module: `dlms_filter`

## Requirements
- R1: While `rst_ni` is low, `y_o` and `e_o` read 0. All weights and all sample history are cleared. After release, `y_o` stays 0 until an update has made a weight nonzero.
- R2: The output pair for sample n appears on `y_o`/`e_o` immediately after the valid edge of sample n+D, with D = 3 + log2(N_TAPS) (6 for 8 taps). Before that, each output holds the value for sample n-D, or 0 when n-D < 0.
- R3: `y(n) = floor( sum_k w_k(n) * x(n-k) / 2^16 )` over k = 0..N_TAPS-1. Weights are 32-bit two's complement with 16 fraction bits. Samples older than the last reset count as zero.
- R4: `e(n) = d(n) - y(n)`, clamped to [-32768, 32767].
- R5: `y(n)` is clamped to [-32768, 32767] when the full-precision sum lies outside that range.
- R6: `w_k(n+1) = w_k(n) + floor( e(n-D) * x(n-D-k) / 2^14 )`, computed in 32-bit wrapping arithmetic. Terms with a negative index are zero.
- R7: A cycle with `valid_i` low changes no state. The values on `x_i` and `d_i` in that cycle are ignored, and `y_o`/`e_o` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Sample strobe; advances every pipeline and the weights |
| x_i | input | 16 | Reference sample, two's complement |
| d_i | input | 16 | Desired sample, two's complement |
| y_o | output | 16 | Filter output, saturated |
| e_o | output | 16 | Error output, saturated |

## Verification
A wrong weight or a wrong partial product stays inside the feedback loop. Once it exists, every later output pair is affected: the faulty term reaches `y_o` D samples after it enters the product path, and it changes later weights through `e_o`. A misaligned tap line or delay line shows up as an output sequence shifted by one sample. Comparing every output pair, sample by sample, against an exact model of the delayed update therefore exposes such faults within a few samples of their first effect. Held-strobe gaps and a training run that drives both clamps cover the remaining corners.

// File: rtl/dlms_pkg.sv
package dlms_pkg;
  localparam int unsigned SAMPLE_W = 16;
  localparam int unsigned COEF_W   = 32;
  localparam int unsigned COEF_FRAC = 16;
  localparam int unsigned MU_SHIFT = 14;
endpackage

// File: rtl/dlms_tap_mult.sv
module dlms_tap_mult #(
  parameter int unsigned XW = 16,
  parameter int unsigned WW = 32,
  localparam int unsigned NG  = XW / 2,
  localparam int unsigned PPW = WW + 2,
  localparam int unsigned PW  = XW + WW
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 en_i,
  input  logic signed [XW-1:0] x_i,
  input  logic signed [WW-1:0] w_i,
  output logic signed [PW-1:0] prod_o
);
  logic [NG-1:0][PPW-1:0] pp_d, pp_q;
  logic signed [PW-1:0]   sum_d;

  // 2-bit cells: lower groups unsigned digit 0..3, top group signed -2..1
  always_comb begin
    logic signed [PPW-1:0] w1, w2;
    w1 = PPW'(w_i);
    w2 = w1 <<< 1;
    for (int g = 0; g < int'(NG); g++) begin
      if (g == int'(NG) - 1) begin
        case (x_i[2*g +: 2])
          2'b00:   pp_d[g] = '0;
          2'b01:   pp_d[g] = w1;
          2'b10:   pp_d[g] = -w2;
          default: pp_d[g] = -w1;
        endcase
      end else begin
        case (x_i[2*g +: 2])
          2'b00:   pp_d[g] = '0;
          2'b01:   pp_d[g] = w1;
          2'b10:   pp_d[g] = w2;
          default: pp_d[g] = w1 + w2;
        endcase
      end
    end
  end

  always_comb begin
    sum_d = '0;
    for (int g = 0; g < int'(NG); g++)
      sum_d = sum_d + (PW'($signed(pp_q[g])) <<< (2 * g));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pp_q   <= '0;
      prod_o <= '0;
    end else if (en_i) begin
      pp_q   <= pp_d;
      prod_o <= sum_d;
    end
  end

  a_r3_zero_operand: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && (x_i == '0 || w_i == '0) |=> pp_q == '0);

  initial begin
    if (XW % 2 != 0) $error("XW must be even");
  end
endmodule

// File: rtl/dlms_adder_tree.sv
module dlms_adder_tree #(
  parameter int unsigned N_LEAF = 8,
  parameter int unsigned IN_W   = 48,
  parameter int unsigned OUT_W  = 51
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        en_i,
  input  logic [N_LEAF-1:0][IN_W-1:0] leaf_i,
  output logic signed [OUT_W-1:0]     sum_o
);
  localparam int unsigned N_NODE = N_LEAF - 1;

  logic signed [OUT_W-1:0] node_q [N_NODE];
  logic signed [OUT_W-1:0] all_w  [2*N_LEAF-1];

  // heap layout: nodes 0..N_NODE-1 registered, leaves follow
  for (genvar i = 0; i < int'(N_NODE); i++) begin : g_node
    assign all_w[i] = node_q[i];
  end
  for (genvar k = 0; k < int'(N_LEAF); k++) begin : g_leaf
    assign all_w[N_NODE + k] = OUT_W'($signed(leaf_i[k]));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(N_NODE); i++) node_q[i] <= '0;
    end else if (en_i) begin
      for (int i = 0; i < int'(N_NODE); i++)
        node_q[i] <= all_w[2*i+1] + all_w[2*i+2];
    end
  end

  assign sum_o = node_q[0];

  initial begin
    if (N_LEAF < 2 || (N_LEAF & (N_LEAF - 1)) != 0) $error("N_LEAF must be a power of two");
  end
endmodule

// File: rtl/dlms_weight_bank.sv
module dlms_weight_bank #(
  parameter int unsigned N_TAPS = 8,
  parameter int unsigned XW     = 16,
  parameter int unsigned WW     = 32,
  parameter int unsigned SHIFT  = 14
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        en_i,
  input  logic signed [XW-1:0]        err_i,
  input  logic [N_TAPS-1:0][XW-1:0]   xd_i,
  output logic [N_TAPS-1:0][WW-1:0]   w_o
);
  logic [N_TAPS-1:0][WW-1:0] w_q, upd_w;

  always_comb begin
    logic signed [2*XW-1:0] p, sh;
    for (int k = 0; k < int'(N_TAPS); k++) begin
      p  = err_i * $signed(xd_i[k]);
      sh = p >>> SHIFT;
      upd_w[k] = WW'(sh);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      w_q <= '0;
    end else if (en_i) begin
      for (int k = 0; k < int'(N_TAPS); k++) w_q[k] <= w_q[k] + upd_w[k];
    end
  end

  assign w_o = w_q;

  a_r7_hold_weights: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(w_q));

  a_r6_zero_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && err_i == '0 |=> $stable(w_q));

  initial begin
    if (WW < 2 * XW) $error("WW must hold the full update product");
  end
endmodule

// File: rtl/dlms_filter.sv
module dlms_filter
  import dlms_pkg::*;
#(
  parameter int unsigned N_TAPS     = 8,
  parameter int unsigned DATA_W     = SAMPLE_W,
  parameter int unsigned WGT_W      = COEF_W,
  parameter int unsigned FRAC_W     = COEF_FRAC,
  parameter int unsigned STEP_SHIFT = MU_SHIFT
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     valid_i,
  input  logic signed [DATA_W-1:0] x_i,
  input  logic signed [DATA_W-1:0] d_i,
  output logic signed [DATA_W-1:0] y_o,
  output logic signed [DATA_W-1:0] e_o
);
  localparam int unsigned LG       = $clog2(N_TAPS);
  localparam int unsigned LAT      = 3 + LG;
  localparam int unsigned PROD_W   = DATA_W + WGT_W;
  localparam int unsigned ACC_W    = PROD_W + LG;
  localparam int unsigned LINE_LEN = N_TAPS + LAT;
  localparam logic [DATA_W-1:0] S_MAX = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic [DATA_W-1:0] S_MIN = {1'b1, {(DATA_W-1){1'b0}}};

  logic [LINE_LEN-1:0][DATA_W-1:0] line_q;
  logic [LAT-1:0][DATA_W-1:0]      d_q;
  logic [N_TAPS-1:0][WGT_W-1:0]    w_w;
  logic [N_TAPS-1:0][PROD_W-1:0]   prod_w;
  logic signed [ACC_W-1:0]         acc_w, yf_w;
  logic signed [DATA_W-1:0]        y_sat, e_sat, d_al;
  logic signed [DATA_W:0]          e_full;

  // extended history: head feeds products, tail (LAT older) feeds the update
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_q <= '0;
      d_q    <= '0;
    end else if (valid_i) begin
      line_q <= {line_q[LINE_LEN-2:0], x_i};
      d_q    <= {d_q[LAT-2:0], d_i};
    end
  end

  for (genvar k = 0; k < int'(N_TAPS); k++) begin : g_tap
    dlms_tap_mult #(.XW(DATA_W), .WW(WGT_W)) u_mult (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (valid_i),
      .x_i    ($signed(line_q[k])),
      .w_i    ($signed(w_w[k])),
      .prod_o (prod_w[k])
    );
  end

  dlms_adder_tree #(.N_LEAF(N_TAPS), .IN_W(PROD_W), .OUT_W(ACC_W)) u_tree (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (valid_i),
    .leaf_i (prod_w),
    .sum_o  (acc_w)
  );

  dlms_weight_bank #(.N_TAPS(N_TAPS), .XW(DATA_W), .WW(WGT_W), .SHIFT(STEP_SHIFT)) u_wts (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (valid_i),
    .err_i  (e_o),
    .xd_i   (line_q[LAT+N_TAPS-1:LAT]),
    .w_o    (w_w)
  );

  assign yf_w = acc_w >>> FRAC_W;
  assign d_al = $signed(d_q[LAT-1]);

  always_comb begin
    if (&yf_w[ACC_W-1:DATA_W-1] || ~|yf_w[ACC_W-1:DATA_W-1]) y_sat = yf_w[DATA_W-1:0];
    else y_sat = yf_w[ACC_W-1] ? S_MIN : S_MAX;
    e_full = {d_al[DATA_W-1], d_al} - {y_sat[DATA_W-1], y_sat};
    if (e_full[DATA_W] == e_full[DATA_W-1]) e_sat = e_full[DATA_W-1:0];
    else e_sat = e_full[DATA_W] ? S_MIN : S_MAX;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      y_o <= '0;
      e_o <= '0;
    end else if (valid_i) begin
      y_o <= y_sat;
      e_o <= e_sat;
    end
  end

  a_r7_hold_outputs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(y_o) && $stable(e_o));

  a_r7_hold_history: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(line_q) && $stable(d_q));
endmodule

// File: tb/dlms_filter_tb.sv
module dlms_filter_tb_top;
  localparam int N  = 8;
  localparam int D  = 3 + $clog2(N);
  localparam int S  = 14;
  localparam int MAXS = 4096;

  localparam int TBL_X [32] = '{ 1200, -800, 3000, 450, -2200, 0, 1750, -3300,
                                 900, 2600, -1500, 60, 4000, -4000, 250, 1300,
                                 -700, 2100, -2900, 800, 1600, -1000, 3500, -50,
                                 700, -1800, 2400, 1100, -3600, 500, 2000, -1200 };
  localparam int TBL_D [32] = '{ 500, -300, 1400, 200, -900, 100, 800, -1500,
                                 350, 1200, -600, 40, 1900, -1800, 90, 650,
                                 -320, 1000, -1300, 380, 760, -470, 1700, -20,
                                 330, -860, 1150, 520, -1700, 240, 950, -560 };

  logic clk = 0, rst_ni = 0, valid_i = 0;
  logic signed [15:0] x_i = 0, d_i = 0;
  logic signed [15:0] y_o, e_o;

  always #2 clk = ~clk;

  dlms_filter dut_i (.clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i),
                     .x_i(x_i), .d_i(d_i), .y_o(y_o), .e_o(e_o));

  int n_run = 0, n_fail = 0;
  int xh [MAXS];
  int yh [MAXS];
  int eh [MAXS];
  int w  [N];
  int ns = 0;

  function automatic int sat16(longint v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return int'(v);
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    ns = 0;
    for (int k = 0; k < N; k++) w[k] = 0;
  endtask

  task automatic model_step(input int xv, input int dv);
    longint acc = 0;
    int n = ns;
    int m;
    xh[n] = xv;
    for (int k = 0; k < N; k++)
      if (n - k >= 0) acc += longint'(w[k]) * longint'(xh[n-k]);
    yh[n] = sat16(acc >>> 16);
    eh[n] = sat16(longint'(dv) - longint'(yh[n]));
    m = n - D;
    if (m >= 0)
      for (int k = 0; k < N; k++)
        if (m - k >= 0) w[k] = w[k] + ((eh[m] * xh[m-k]) >>> S);
    ns++;
  endtask

  task automatic push(input int xv, input int dv);
    @(negedge clk);
    valid_i = 1; x_i = xv[15:0]; d_i = dv[15:0];
    @(posedge clk); #1;
    valid_i = 0;
    model_step(xv, dv);
    // R3 R5 R6: output follows the delayed-update model; R4 error path
    check("R3_R6 y", int'(y_o), (ns - 1 - D >= 0) ? yh[ns-1-D] : 0);
    check("R4 e",    int'(e_o), (ns - 1 - D >= 0) ? eh[ns-1-D] : 0);
  endtask

  task automatic idle(input int xv, input int dv);
    int py, pe;
    @(negedge clk);
    py = int'(y_o); pe = int'(e_o);
    valid_i = 0; x_i = xv[15:0]; d_i = dv[15:0];
    @(posedge clk); #1;
    check("R7 y hold", int'(y_o), py);
    check("R7 e hold", int'(e_o), pe);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin : main
    model_reset();
    repeat (3) @(posedge clk);
    #1;
    check("R1 y in reset", int'(y_o), 0);
    check("R1 e in reset", int'(e_o), 0);
    @(negedge clk) rst_ni = 1;

    // R2: single desired pulse with zero input, error appears after D samples
    push(0, 1234);
    for (int j = 1; j <= D; j++) begin
      push(0, 0);
      if (j == D - 1) check("R2 e before latency", int'(e_o), 0);
      if (j == D)     check("R2 e at latency", int'(e_o), 1234);
    end

    // table walk
    for (int i = 0; i < 32; i++) push(TBL_X[i], TBL_D[i]);

    // R7: gaps with garbage inputs
    for (int i = 0; i < 16; i++) begin
      push(TBL_X[31-i], TBL_D[31-i]);
      idle(-31000 + i * 97, 29000 - i * 53);
      idle(12345, -12345);
    end

    // training toward a large gain, then drive both clamps (R5, R4)
    for (int i = 0; i < 600; i++) push(1000, 32767);
    for (int j = 0; j < 16; j++) begin
      push(32767, 32767);
      if (j >= D) check("R5 y clamp high", int'(y_o), 32767);
    end
    for (int j = 0; j < 16; j++) begin
      push(-32768, 32767);
      if (j == 7 + D) begin
        check("R5 y clamp low", int'(y_o), -32768);
        check("R4 e clamp high", int'(e_o), 32767);
      end
    end

    // R1: mid-run reset clears weights and history
    @(negedge clk) rst_ni = 0;
    @(posedge clk); #1;
    check("R1 y after reset", int'(y_o), 0);
    check("R1 e after reset", int'(e_o), 0);
    @(negedge clk) rst_ni = 1;
    model_reset();
    for (int j = 0; j <= D; j++) begin
      push(20000, 0);
      if (j == D) check("R1 weights cleared", int'(y_o), 0);
    end
    for (int i = 0; i < 32; i++) push(TBL_D[i] * 3, TBL_X[i]);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule